// File: doc/BRIEF.md
# Audio Packet Transmit Controller

This block sits between an 8-bit audio converter front end and a byte-wide serial transmitter on a shared wire. An internal rate divider paces sampling. On every sample tick the block pulses `smp_tick` and takes in the unsigned 8-bit value on `smp_in`. That value goes into a 64-entry first-in first-out buffer. Samples are never framed straight from the converter: they always pass through the buffer first.

Once at least 16 samples are buffered and the line-busy input shows the wire idle, the block sends one packet. A packet is a header byte copied from `cfg_byte`, captured when the packet starts, followed by the 16 oldest samples in arrival order. Bytes leave over a valid/ready handshake. A byte is transferred on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the transmitter exerts back-pressure, and the block holds `tx_valid` and `tx_data` unchanged. After a packet has begun, it runs to its last byte whatever the line does.

The configuration byte carries the rate mode in bits 7:6, the destination station in bits 5:3 and the source station in bits 2:0. The header is that byte copied unchanged. A sample that arrives while the buffer is full is lost, and it sets a sticky overflow flag. Pressing both push-buttons together is wired outside the block to `rst_n`.

Top module: `audio_pkt_tx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `tx_valid` and `ovf` are 0.
- R2: With `cfg_byte[7:6]` equal to 00, 10 or 11, `smp_tick` pulses for one cycle every `DIV_BASE` clocks.
- R3: With `cfg_byte[7:6]` equal to 01, `smp_tick` pulses every `DIV_BASE/2` clocks.
- R4: `tx_valid` rises only on the cycle after one in which `line_busy` was 0. It does rise on that cycle when the buffer held 16 or more samples and no packet was in progress.
- R5: A packet is 17 accepted bytes. The first is the `cfg_byte` value from the cycle before `tx_valid` rose. The next 16 are buffered samples, oldest first, each equal to `smp_in` on its tick cycle.
- R6: Once `tx_valid` has risen, it stays high until all 17 bytes are accepted, whatever `line_busy` does.
- R7: When `tx_valid` is high and `tx_ready` is low, the next cycle has `tx_valid` high and the same `tx_data`.
- R8: A tick that finds 64 samples stored drops that sample. It sets `ovf` on the next cycle, and `ovf` stays 1 until reset. Samples already stored are sent unchanged.
- R9: `tx_valid` never rises while fewer than 16 samples are buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_byte | input | 8 | Rate mode [7:6], destination [5:3], source [2:0] |
| smp_in | input | 8 | Unsigned sample from converter |
| smp_tick | output | 1 | Sample taken this cycle |
| line_busy | input | 1 | Shared wire in use |
| tx_data | output | 8 | Byte to transmitter |
| tx_valid | output | 1 | `tx_data` valid |
| tx_ready | input | 1 | Transmitter accepts byte |
| ovf | output | 1 | Sticky sample-drop flag |

## Verification
A corrupted buffer pointer or count shows up at the first packet byte transferred after it. That byte is a stale or reordered sample, or the start of the packet comes at the wrong time against the buffered count. A stuck framer byte index shows up within one packet, as 16 samples sent but not 16 stored, or as a `tx_valid` drop in the middle of a packet. A wrong divider limit shows up on the second tick after a mode settles, as a wrong spacing between ticks.

// File: rtl/apt_pkg.sv
package apt_pkg;
  typedef enum logic [1:0] {
    RATE_BASE = 2'b00,
    RATE_HI   = 2'b01,
    RATE_X2   = 2'b10,
    RATE_X3   = 2'b11
  } rate_mode_e;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_HEAD,
    FR_BODY
  } fr_state_e;
endpackage

// File: rtl/apt_rate_div.sv
module apt_rate_div
  import apt_pkg::*;
#(
  parameter int DIV_BASE = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  output logic       tick
);
  localparam int DIV_W = $clog2(DIV_BASE + 1);
  localparam logic [DIV_W-1:0] LIM_BASE = DIV_W'(DIV_BASE);
  localparam logic [DIV_W-1:0] LIM_HI   = DIV_W'(DIV_BASE / 2);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim  = (rate_mode_e'(mode) == RATE_HI) ? LIM_HI : LIM_BASE;
    tick = (cnt >= lim - DIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);
  end

  // R2: counter never passes the base limit
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < LIM_BASE);
  // R3: a tick is always followed by a gap
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/apt_sample_fifo.sv
module apt_sample_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         rd_en,
  output logic [DW-1:0]                rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr;

  always_comb begin
    full    = (count == CNT_W'(DEPTH));
    do_wr   = wr_en && !full;
    rd_data = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({do_wr, rd_en})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R8: storage never exceeds depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R8: a push into a full buffer without a pop leaves it full
  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> full);
  // R9: never read from an empty buffer
  a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (count != '0));
endmodule

// File: rtl/apt_framer.sv
module apt_framer
  import apt_pkg::*;
#(
  parameter int PKT_LEN = 16,
  parameter int CNT_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cfg,
  input  logic             line_busy,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [7:0]       fifo_head,
  output logic             pop,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready
);
  localparam int IW = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
  localparam logic [IW-1:0] LAST = IW'(PKT_LEN - 1);

  fr_state_e     state;
  logic [IW-1:0] idx;
  logic [7:0]    hdr_q;

  always_comb begin
    tx_valid = (state != FR_IDLE);
    tx_data  = (state == FR_HEAD) ? hdr_q : fifo_head;
    pop      = (state == FR_BODY) && tx_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= FR_IDLE;
      idx   <= '0;
      hdr_q <= '0;
    end else begin
      case (state)
        FR_IDLE: if (fifo_count >= CNT_W'(PKT_LEN) && !line_busy) begin
          state <= FR_HEAD;
          hdr_q <= cfg;
        end
        FR_HEAD: if (tx_ready) begin
          state <= FR_BODY;
          idx   <= '0;
        end
        FR_BODY: if (tx_ready) begin
          if (idx == LAST) state <= FR_IDLE;
          else             idx   <= idx + IW'(1);
        end
        default: state <= FR_IDLE;
      endcase
    end
  end

  // R7: byte held under back-pressure
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R4: packet begins only after a free-line cycle
  a_r4_start_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(!line_busy));
  // R6: no abort in the middle of a packet
  a_r6_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_HEAD) |=> tx_valid);
endmodule

// File: rtl/audio_pkt_tx.sv
module audio_pkt_tx #(
  parameter int DIV_BASE = 25000,
  parameter int DEPTH    = 64,
  parameter int PKT_LEN  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg_byte,
  input  logic [7:0] smp_in,
  output logic       smp_tick,
  input  logic       line_busy,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic       ovf
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             tick;
  logic             pop;
  logic             full;
  logic [CNT_W-1:0] fcount;
  logic [7:0]       fhead;

  apt_rate_div #(.DIV_BASE(DIV_BASE)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (cfg_byte[7:6]),
    .tick (tick)
  );

  apt_sample_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tick),
    .wr_data(smp_in),
    .rd_en  (pop),
    .rd_data(fhead),
    .count  (fcount),
    .full   (full)
  );

  apt_framer #(.PKT_LEN(PKT_LEN), .CNT_W(CNT_W)) u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg_byte),
    .line_busy (line_busy),
    .fifo_count(fcount),
    .fifo_head (fhead),
    .pop       (pop),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             ovf <= 1'b0;
    else if (tick && full)  ovf <= 1'b1;
  end

  assign smp_tick = tick;

  // R8: flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R8: a drop raises the flag
  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && full) |=> ovf);
endmodule

// File: tb/tb_audio_pkt_tx.sv
module tb_audio_pkt_tx;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic [7:0] smp_in = 8'h00;
  logic       line_busy = 1'b1;
  logic       tx_ready = 1'b0;
  logic       smp_tick, tx_valid, ovf;
  logic [7:0] tx_data;

  audio_pkt_tx #(.DIV_BASE(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .smp_in(smp_in),
    .smp_tick(smp_tick), .line_busy(line_busy), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .ovf(ovf)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] q[$];
  bit         ovf_m;
  int         pos;
  bit         pv, pr, lbp;
  logic [7:0] pd, cfgp, hdr_exp;
  int         szp;
  int         last_tick;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d cyc=%0d", req, act, exp, cyc);
    end
  endtask

  function automatic int lim_of(input logic [1:0] m);
    return (m == 2'b01) ? DIV / 2 : DIV;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
    if (!rst_n) begin
      q.delete();
      ovf_m = 0; pos = 0; pv = 0; pr = 0; lbp = 1; szp = 0;
      last_tick = -1; cfgp = cfg_byte; pd = 0;
    end else begin
      if (cfg_byte != cfgp) last_tick = -1;
      chk(ovf == ovf_m, "R8 ovf", ovf, ovf_m);
      if (tx_valid && !pv) begin
        chk(lbp == 1'b0, "R4 start while busy", lbp, 0);
        chk(szp >= 16, "R9 start underfilled", szp, 16);
        hdr_exp = cfgp;
      end
      if (!tx_valid && !pv && !lbp && szp >= 16)
        chk(1'b0, "R4 missed start", 0, 1);
      if (pos != 0 && !tx_valid)
        chk(1'b0, "R6 valid dropped mid packet", 0, 1);
      if (pv && !pr)
        chk(tx_valid && tx_data == pd, "R7 hold", tx_data, pd);
      if (smp_tick) begin
        if (last_tick >= 0) begin
          if (cfg_byte[7:6] == 2'b01)
            chk(cyc - last_tick == lim_of(2'b01), "R3 tick spacing", cyc - last_tick, lim_of(2'b01));
          else
            chk(cyc - last_tick == lim_of(cfg_byte[7:6]), "R2 tick spacing", cyc - last_tick, lim_of(cfg_byte[7:6]));
        end
        last_tick = cyc;
      end
      szp = q.size();
      begin
        bit was_full;
        was_full = (q.size() >= 64);
        if (tx_valid && tx_ready) begin
          if (pos == 0) chk(tx_data == hdr_exp, "R5 header", tx_data, hdr_exp);
          else if (q.size() == 0) chk(1'b0, "R5 underrun", 0, 1);
          else begin
            chk(tx_data == q[0], "R5 sample", tx_data, q[0]);
            void'(q.pop_front());
          end
          pos = (pos == 16) ? 0 : pos + 1;
        end
        if (smp_tick) begin
          if (was_full) ovf_m = 1;
          else q.push_back(smp_in);
        end
      end
      pv = tx_valid; pr = tx_ready; pd = tx_data; lbp = line_busy; cfgp = cfg_byte;
    end
  end

  task automatic run(input int n, input int rdy_pct, input int busy_pct);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      smp_in    = 8'($urandom);
      tx_ready  = ($urandom % 100) < rdy_pct;
      line_busy = ($urandom % 100) < busy_pct;
    end
  endtask

  task automatic set_cfg(input logic [7:0] v);
    @(posedge clk); #1;
    line_busy = 1'b1;
    tx_ready  = 1'b1;
    while (tx_valid) begin @(posedge clk); #1; end
    cfg_byte = v;
  endtask

  initial begin
    void'($urandom(32'd4242));
    cfg_byte = 8'b00_011_101;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_valid == 0, "R1 valid in reset", tx_valid, 0);
    chk(ovf == 0, "R1 ovf in reset", ovf, 0);
    @(posedge clk); #1; rst_n = 1'b1; line_busy = 1'b0;
    @(negedge clk);
    chk(tx_valid == 0, "R1 valid after reset", tx_valid, 0);
    chk(ovf == 0, "R1 ovf after reset", ovf, 0);
    // free line, first packet waits for 16 samples (R9)
    run(200, 100, 0);
    run(3000, 70, 15);
    set_cfg(8'b01_110_010);
    run(3000, 60, 20);
    // overflow: hold line busy (R8)
    set_cfg(8'b00_001_111);
    @(posedge clk); #1; line_busy = 1'b1;
    repeat (700) @(posedge clk);
    #1;
    @(negedge clk);
    chk(ovf == 1, "R8 ovf set", ovf, 1);
    run(1500, 50, 5);
    @(negedge clk);
    chk(ovf == 1, "R8 ovf sticky", ovf, 1);
    set_cfg(8'b11_100_001);
    run(1000, 100, 10);
    set_cfg(8'b10_010_100);
    run(600, 30, 50);
    @(posedge clk); #1; rst_n = 1'b0;
    @(negedge clk);
    @(posedge clk); #1;
    @(negedge clk);
    chk(ovf == 0, "R8 ovf cleared by reset", ovf, 0);
    chk(tx_valid == 0, "R1 valid cleared by reset", tx_valid, 0);
    finish_run();
  end
endmodule